// File: doc/BRIEF.md
# I2C Host Bus Timeout Monitor

This block sits beside the byte engine of an I2C host and watches the synchronized SCL and SDA levels for two kinds of stalls. The first is an SCL line that stays low for about 30 ms. When that watchdog is enabled and it expires, the block pulses a request to send a STOP and end the transaction. If the host is holding the clock at that moment, it also pulses a request to release the hold. In addition it sets two sticky status bits, one for low timeout and one for bus error.

The second stall is an inactive bus: SCL is held low, by any device, for a selectable number of SCL bit periods. When this happens the block pulses a request that forces the bus state logic back to idle. Each timer has its own prescaler, which derives its tick from the core clock: a millisecond tick for the watchdog and an SCL-period tick for the inactivity timer. Every SCL edge restarts both timers. An SDA edge, which is also bus activity, restarts the inactivity timer.

Top module: `i2c_bus_timeout_mon`

## Requirements
- R1: While reset is high, and after it is released, every output is 0.
- R2: With `lowto_en` = 1, `gen_stop_o` is a single-cycle pulse. It appears after the clock edge that comes LOW_TICKS×MS_DIV clocks after the restart edge. The restart edge is the first clock edge that samples SCL low, or the last edge at which the watchdog was disabled.
- R3: `release_hold_o` pulses in the same cycle as `gen_stop_o` only if `hold_active` was 1 in the cycle the timeout expired. Otherwise it stays 0.
- R4: A low timeout sets both `lowto_sts_o` and `buserr_sts_o`. They stay set until a one-cycle `status_clr` pulse, which clears them at the next edge. A set in the same cycle as a clear wins.
- R5: Each timer fires at most once per continuous stretch of SCL low. It does not fire again until SCL toggles.
- R6: An SCL edge restarts both timers. SCL low stretches that are each shorter than the limit produce no event and no status.
- R7: With `lowto_en` = 0 the watchdog is held in reset. It produces no pulse and no status, and enabling it again restarts its count from zero.
- R8: The `inact_sel` encoding is 0 = off, 1 = 5, 2 = 10 and 3 = 20 SCL periods. `force_idle_o` pulses after the clock edge that comes N×SCL_DIV clocks after the restart edge.
- R9: An SDA edge while SCL is low restarts the inactivity timer but not the low-timeout watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Synchronized SCL level |
| sda_in | input | 1 | Synchronized SDA level |
| hold_active | input | 1 | Host engine is stretching SCL |
| lowto_en | input | 1 | Enable for the SCL-low watchdog |
| inact_sel | input | 2 | Inactivity limit select |
| status_clr | input | 1 | Clears both sticky status bits |
| release_hold_o | output | 1 | Pulse: release clock hold |
| gen_stop_o | output | 1 | Pulse: generate STOP |
| force_idle_o | output | 1 | Pulse: force bus state to idle |
| lowto_sts_o | output | 1 | Sticky low-timeout status |
| buserr_sts_o | output | 1 | Sticky bus-error status |

## Verification
The bench holds SCL low well past each limit, with the clock hold asserted and then deasserted. This separates the STOP-plus-release response from the STOP-only response and shows that the events do not repeat. It then breaks SCL low into stretches just under the limit, so a timer that fails to restart would show up as a spurious event. Each inactivity select value is run with the watchdog off, which pins the exact period count for each code. A final run toggles SDA partway through a low stretch with both timers on. This shows that only the inactivity timer moves, while the watchdog keeps its original expiry cycle.

// File: rtl/i2c_tmo_pkg.sv
package i2c_tmo_pkg;
  localparam int INACT_W = 5;

  typedef enum logic [1:0] {
    INACT_OFF   = 2'd0,
    INACT_SHORT = 2'd1,
    INACT_MID   = 2'd2,
    INACT_LONG  = 2'd3
  } inact_sel_e;

  function automatic logic [INACT_W-1:0] inact_ticks(input logic [1:0] sel);
    case (inact_sel_e'(sel))
      INACT_SHORT: inact_ticks = INACT_W'(5);
      INACT_MID:   inact_ticks = INACT_W'(10);
      INACT_LONG:  inact_ticks = INACT_W'(20);
      default:     inact_ticks = INACT_W'(0);
    endcase
  endfunction
endpackage

// File: rtl/line_edge_det.sv
module line_edge_det #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lines,
  output logic [N-1:0] edges
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) prev_q[i] <= 1'b1;
      else     prev_q[i] <= lines[i];
    end
    assign edges[i] = lines[i] ^ prev_q[i];
  end
endmodule

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int DIV = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic restart,
  output logic tick
);
  localparam int DW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] cnt_q;

  assign tick = active && !restart && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !active || restart) cnt_q <= '0;
    else if (cnt_q == LAST)        cnt_q <= '0;
    else                           cnt_q <= cnt_q + DW'(1);
  end

  a_r6_restart_clears_tick: assert property (@(posedge clk) disable iff (rst)
    restart |=> !tick);
endmodule

// File: rtl/tick_timeout.sv
module tick_timeout #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         active,
  input  logic         restart,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         fire
);
  logic [W-1:0] cnt_q;
  logic         room;

  assign room = (limit != '0) && (cnt_q != limit);
  assign fire = active && !restart && tick && room && ((cnt_q + W'(1)) == limit);

  always_ff @(posedge clk) begin
    if (rst || !active || restart) cnt_q <= '0;
    else if (tick && room)         cnt_q <= cnt_q + W'(1);
  end

  a_r5_fire_once: assert property (@(posedge clk) disable iff (rst)
    fire |=> !fire);
endmodule

// File: rtl/i2c_bus_timeout_mon.sv
module i2c_bus_timeout_mon
  import i2c_tmo_pkg::*;
#(
  parameter int MS_DIV    = 100000,
  parameter int SCL_DIV   = 1000,
  parameter int LOW_TICKS = 30
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic       hold_active,
  input  logic       lowto_en,
  input  logic [1:0] inact_sel,
  input  logic       status_clr,
  output logic       release_hold_o,
  output logic       gen_stop_o,
  output logic       force_idle_o,
  output logic       lowto_sts_o,
  output logic       buserr_sts_o
);
  localparam int LOW_W = $clog2(LOW_TICKS + 1);
  localparam logic [LOW_W-1:0] LOW_LIMIT = LOW_W'(LOW_TICKS);

  logic [1:0] edges;
  logic       scl_low, low_active, inact_active, inact_restart;
  logic       ms_tick, per_tick, low_fire, inact_fire;

  line_edge_det #(.N(2)) u_edges (
    .clk(clk), .rst(rst), .lines({sda_in, scl_in}), .edges(edges)
  );

  assign scl_low       = !scl_in;
  assign low_active    = lowto_en && scl_low;
  assign inact_active  = (inact_sel != 2'd0) && scl_low;
  assign inact_restart = edges[0] || edges[1];

  tick_divider #(.DIV(MS_DIV)) u_ms_div (
    .clk(clk), .rst(rst), .active(low_active), .restart(edges[0]), .tick(ms_tick)
  );

  tick_timeout #(.W(LOW_W)) u_low_tmo (
    .clk(clk), .rst(rst), .active(low_active), .restart(edges[0]),
    .tick(ms_tick), .limit(LOW_LIMIT), .fire(low_fire)
  );

  tick_divider #(.DIV(SCL_DIV)) u_per_div (
    .clk(clk), .rst(rst), .active(inact_active), .restart(inact_restart), .tick(per_tick)
  );

  tick_timeout #(.W(INACT_W)) u_inact_tmo (
    .clk(clk), .rst(rst), .active(inact_active), .restart(inact_restart),
    .tick(per_tick), .limit(inact_ticks(inact_sel)), .fire(inact_fire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gen_stop_o     <= 1'b0;
      release_hold_o <= 1'b0;
      force_idle_o   <= 1'b0;
      lowto_sts_o    <= 1'b0;
      buserr_sts_o   <= 1'b0;
    end else begin
      gen_stop_o     <= low_fire;
      release_hold_o <= low_fire && hold_active;
      force_idle_o   <= inact_fire;
      lowto_sts_o    <= low_fire || (lowto_sts_o && !status_clr);
      buserr_sts_o   <= low_fire || (buserr_sts_o && !status_clr);
    end
  end

  a_r4_stop_sets_status: assert property (@(posedge clk) disable iff (rst)
    gen_stop_o |-> (lowto_sts_o && buserr_sts_o));
  a_r3_release_needs_hold: assert property (@(posedge clk) disable iff (rst)
    release_hold_o |-> ($past(hold_active) && gen_stop_o));
  a_r4_status_sticky: assert property (@(posedge clk) disable iff (rst)
    ($past(lowto_sts_o) && !$past(status_clr)) |-> lowto_sts_o);
  a_r5_single_stop: assert property (@(posedge clk) disable iff (rst)
    gen_stop_o |=> !gen_stop_o);
  a_r7_disabled_no_stop: assert property (@(posedge clk) disable iff (rst)
    !$past(lowto_en) |-> !gen_stop_o);
  a_r8_idle_needs_select: assert property (@(posedge clk) disable iff (rst)
    force_idle_o |-> ($past(inact_sel) != 2'd0));
endmodule

// File: tb/sim_i2c_bus_timeout_mon.sv
module sim_i2c_bus_timeout_mon;
  localparam int MSD = 20;
  localparam int SCD = 8;
  localparam int LT  = 30;
  localparam int LOWC = LT * MSD;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1, sda = 1'b1, hold = 1'b0, en = 1'b0, clr = 1'b0;
  logic [1:0] sel = 2'd0;
  logic rel, stp, idl, lsts, bsts;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  typedef struct { int kind; int at; string req; } exp_t;
  exp_t expq[$];

  always #5 clk = ~clk;
  always_ff @(posedge clk) cyc <= cyc + 1;

  i2c_bus_timeout_mon #(.MS_DIV(MSD), .SCL_DIV(SCD), .LOW_TICKS(LT)) u0 (
    .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda), .hold_active(hold),
    .lowto_en(en), .inact_sel(sel), .status_clr(clr),
    .release_hold_o(rel), .gen_stop_o(stp), .force_idle_o(idl),
    .lowto_sts_o(lsts), .buserr_sts_o(bsts)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic push(input int kind, input int at, input string req);
    exp_t e;
    e.kind = kind; e.at = at; e.req = req;
    expq.push_back(e);
  endtask

  task automatic idle_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: kinds 0 = stop, 1 = release, 2 = force idle
  always @(negedge clk) begin
    if (!rst) begin
      while (expq.size() > 0 && expq[0].at < cyc) begin
        chk(1'b0, {expq[0].req, " missed pulse"}, 0, 1);
        void'(expq.pop_front());
      end
      for (int k = 0; k < 3; k++) begin
        logic s;
        s = (k == 0) ? stp : (k == 1) ? rel : idl;
        if (s) begin
          if (expq.size() > 0 && expq[0].kind == k && expq[0].at == cyc) begin
            chk(1'b1, expq[0].req, k, k);
            void'(expq.pop_front());
          end else begin
            chk(1'b0, "R5/R6 unexpected pulse kind", k, -1);
          end
        end
      end
    end
  end

  task automatic clear_status();
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    chk(!lsts && !bsts, "R4 clear", {lsts, bsts}, 0);
  endtask

  initial begin
    int t;
    idle_cyc(3);
    chk({rel, stp, idl, lsts, bsts} == 5'b0, "R1 in reset", {rel, stp, idl, lsts, bsts}, 0);
    rst = 1'b0;
    idle_cyc(2);
    chk({rel, stp, idl, lsts, bsts} == 5'b0, "R1 after reset", {rel, stp, idl, lsts, bsts}, 0);

    // R2/R3/R4/R5: low timeout with hold asserted
    en = 1'b1; hold = 1'b1;
    scl = 1'b0; t = cyc;
    push(0, t + 1 + LOWC, "R2 stop timing");
    push(1, t + 1 + LOWC, "R3 release with hold");
    idle_cyc(LOWC + 100);
    chk(lsts && bsts, "R4 both status set", {lsts, bsts}, 3);
    scl = 1'b1; idle_cyc(50);
    chk(lsts && bsts, "R4 sticky", {lsts, bsts}, 3);
    clear_status();

    // R3: no hold -> stop only
    hold = 1'b0;
    scl = 1'b0; t = cyc;
    push(0, t + 1 + LOWC, "R3 stop without hold");
    idle_cyc(LOWC + 20);
    scl = 1'b1; idle_cyc(5);
    clear_status();

    // R6: short stretches restart the watchdog
    for (int i = 0; i < 3; i++) begin
      scl = 1'b0; idle_cyc(LOWC - 50);
      scl = 1'b1; idle_cyc(2);
    end
    chk(!lsts && !bsts, "R6 no status after short lows", {lsts, bsts}, 0);

    // R7: disabled watchdog
    en = 1'b0; scl = 1'b0; idle_cyc(LOWC + 100);
    chk(!lsts, "R7 disabled no status", lsts, 0);
    // R7: re-enable restarts from zero
    t = cyc; en = 1'b1;
    push(0, t + LOWC, "R7 re-enable restart");
    idle_cyc(LOWC + 20);
    scl = 1'b1; en = 1'b0; idle_cyc(5);
    clear_status();

    // R8: inactivity select codes
    for (int s = 1; s < 4; s++) begin
      int n;
      n = (s == 1) ? 5 : (s == 2) ? 10 : 20;
      sel = 2'(s);
      idle_cyc(2);
      scl = 1'b0; t = cyc;
      push(2, t + 1 + n * SCD, "R8 idle timing");
      idle_cyc(n * SCD + 40);
      scl = 1'b1; idle_cyc(3);
    end
    chk(!lsts, "R8 inactivity leaves status", lsts, 0);
    sel = 2'd0; idle_cyc(2);
    scl = 1'b0; idle_cyc(300); scl = 1'b1; idle_cyc(3);
    chk(1'b1, "R8 select 0 off", 0, 0);

    // R9: SDA edge restarts inactivity only
    sel = 2'd1; en = 1'b1; idle_cyc(2);
    scl = 1'b0; t = cyc;
    idle_cyc(20);
    sda = 1'b0;
    push(2, cyc + 1 + 5 * SCD, "R9 sda restart idle");
    push(0, t + 1 + LOWC, "R9 watchdog unaffected");
    idle_cyc(LOWC + 20);
    scl = 1'b1; sda = 1'b1; idle_cyc(5);
    chk(lsts, "R9 status from watchdog", lsts, 1);

    idle_cyc(5);
    chk(expq.size() == 0, "R5 all expected pulses seen", expq.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #1500000;
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule